// File: doc/BRIEF.md
# Multi-Latency Execution Scheduler

This block decides when instructions may enter an execution stage whose functional units need different numbers of cycles. It also decides when their results may be written back. At most one instruction is offered per cycle. Each instruction carries a unit class, one destination register and two source registers. The block computes no data. It models only timing and ordering: how long each instruction stays in flight, which instructions must wait, and which finished result goes through the single writeback port.

Issue waits in three cases: a source or the destination register still has a result pending, six instructions are already in flight, or a divide is requested while another divide is outstanding. In flight, each instruction counts down its class latency. Once finished, it competes for writeback, and the oldest finished instruction is granted first.

Top module: `fu_sched`

## Requirements
- R1: After reset no instruction is in flight, `wb_valid` is 0, `inflight` is 0 and `iss_ready` is 1.
- R2: Class codes on `iss_cls` are 0 integer add/subtract, 1 memory reference, 2 FP add, 3 multiply and 4 divide, with latencies of 1, 1, 2, 6 and 15 cycles. An instruction accepted at clock edge E0 of latency L first shows `wb_valid`=1 with its own `wb_dst` in the cycle following edge E(L-1), provided no older result is competing.
- R3: FP add and multiply are pipelined. A second multiply is accepted on the edge right after the first, and the two write back in consecutive cycles.
- R4: Only one divide may be in flight. A divide offered while another is outstanding sees `iss_ready`=0, while other classes remain free to issue.
- R5: A read-after-write hazard holds issue. If either source register equals the destination of an in-flight instruction, `iss_ready` is 0 until the edge that writes that result back has passed.
- R6: A write-after-write hazard holds issue. If the destination register equals the destination of an in-flight instruction, `iss_ready` is 0.
- R7: No more than six instructions are in flight, and with six in flight `iss_ready` is 0.
- R8: The writeback port carries at most one result per cycle. When several results are finished, the one issued earliest goes first.
- R9: A finished result that loses arbitration stays held without loss and is written back in a later cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | An instruction is offered this cycle |
| iss_cls | input | 3 | Unit class code of the offered instruction |
| iss_dst | input | 5 | Destination register |
| iss_src_a | input | 5 | First source register |
| iss_src_b | input | 5 | Second source register |
| iss_ready | output | 1 | Offered instruction can be accepted this cycle |
| wb_valid | output | 1 | A result is written back this cycle |
| wb_dst | output | 5 | Register written back |
| wb_seq | output | 6 | Issue sequence number of the written-back instruction |
| inflight | output | 3 | Number of instructions in flight |

## Verification
Each class is first issued alone into an empty block, so the measured cycle count exposes any error in a latency or in a class decode. Two back-to-back multiplies separate a pipelined unit from a blocking one, and a divide followed by a second divide and then an integer operation shows that only the divide unit blocks. Hazard patterns place the dependent register on each source field and on the destination in turn, and they check that readiness returns exactly one edge after writeback. A multiply and an FP add timed to finish together show both the oldest-first choice and the later delivery of the loser. Six back-to-back multiplies then fill every slot.

// File: rtl/fu_sched_pkg.sv
package fu_sched_pkg;
  typedef enum logic [2:0] {
    CLS_INT  = 3'd0,
    CLS_MEM  = 3'd1,
    CLS_FADD = 3'd2,
    CLS_MUL  = 3'd3,
    CLS_DIV  = 3'd4
  } fu_cls_e;

  localparam int LAT_W    = 4;
  localparam int LAT_INT  = 1;
  localparam int LAT_MEM  = 1;
  localparam int LAT_FADD = 2;
  localparam int LAT_MUL  = 6;
  localparam int LAT_DIV  = 15;

  // countdown value loaded at issue: latency minus the issue edge itself
  function automatic logic [LAT_W-1:0] cls_wait(input logic [2:0] c);
    case (c)
      CLS_INT:  cls_wait = LAT_W'(LAT_INT - 1);
      CLS_MEM:  cls_wait = LAT_W'(LAT_MEM - 1);
      CLS_FADD: cls_wait = LAT_W'(LAT_FADD - 1);
      CLS_MUL:  cls_wait = LAT_W'(LAT_MUL - 1);
      CLS_DIV:  cls_wait = LAT_W'(LAT_DIV - 1);
      default:  cls_wait = '0;
    endcase
  endfunction

  function automatic logic seq_older(input logic [7:0] a, input logic [7:0] b, input int w);
    logic [7:0] d;
    d = a - b;
    seq_older = d[w-1];
  endfunction
endpackage

// File: rtl/fu_sched_slot.sv
module fu_sched_slot #(
  parameter int SEQ_W = 6,
  parameter int REG_W = 5,
  parameter int LAT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc,
  input  logic [REG_W-1:0] a_dst,
  input  logic [SEQ_W-1:0] a_seq,
  input  logic [LAT_W-1:0] a_wait,
  input  logic             a_div,
  input  logic             release_i,
  output logic             vld,
  output logic             done,
  output logic [REG_W-1:0] dst,
  output logic [SEQ_W-1:0] seq,
  output logic             is_div
);
  logic             vld_q, vld_d, div_q, div_d;
  logic [LAT_W-1:0] rem_q, rem_d;
  logic [REG_W-1:0] dst_q, dst_d;
  logic [SEQ_W-1:0] seq_q, seq_d;

  always_comb begin
    vld_d = vld_q;
    rem_d = rem_q;
    dst_d = dst_q;
    seq_d = seq_q;
    div_d = div_q;
    if (alloc) begin
      vld_d = 1'b1;
      rem_d = a_wait;
      dst_d = a_dst;
      seq_d = a_seq;
      div_d = a_div;
    end else if (release_i) begin
      vld_d = 1'b0;
      div_d = 1'b0;
    end else if (vld_q && rem_q != '0) begin
      rem_d = rem_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      rem_q <= '0;
      dst_q <= '0;
      seq_q <= '0;
      div_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      rem_q <= rem_d;
      div_q <= div_d;
      if (alloc) begin
        dst_q <= dst_d;
        seq_q <= seq_d;
      end
    end
  end

  assign vld    = vld_q;
  assign done   = vld_q && (rem_q == '0);
  assign dst    = dst_q;
  assign seq    = seq_q;
  assign is_div = div_q;
endmodule

// File: rtl/fu_sched_wbarb.sv
module fu_sched_wbarb #(
  parameter int NSLOT = 6,
  parameter int SEQ_W = 6
) (
  input  logic [NSLOT-1:0] done,
  input  logic [SEQ_W-1:0] seq [NSLOT],
  output logic [NSLOT-1:0] gnt
);
  localparam int IDX_W = $clog2(NSLOT);

  logic             found;
  logic [IDX_W-1:0] best;
  logic [SEQ_W-1:0] best_seq;
  logic [SEQ_W-1:0] diff;

  always_comb begin
    found    = 1'b0;
    best     = '0;
    best_seq = '0;
    diff     = '0;
    gnt      = '0;
    for (int i = 0; i < NSLOT; i++) begin
      diff = seq[i] - best_seq;
      if (done[i] && (!found || diff[SEQ_W-1])) begin
        found    = 1'b1;
        best     = IDX_W'(i);
        best_seq = seq[i];
      end
    end
    if (found) gnt[best] = 1'b1;
  end
endmodule

// File: rtl/fu_sched_sb.sv
module fu_sched_sb #(
  parameter int NREG  = 32,
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [REG_W-1:0] set_idx,
  input  logic             clr_en,
  input  logic [REG_W-1:0] clr_idx,
  output logic [NREG-1:0]  busy
);
  logic [NREG-1:0] busy_q, busy_d;

  always_comb begin
    busy_d = busy_q;
    if (clr_en) busy_d[clr_idx] = 1'b0;
    if (set_en) busy_d[set_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= '0;
    else if (set_en || clr_en) busy_q <= busy_d;
  end

  assign busy = busy_q;
endmodule

// File: rtl/fu_sched.sv
module fu_sched #(
  parameter int NSLOT = 6,
  parameter int REG_W = 5,
  parameter int SEQ_W = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       iss_valid,
  input  logic [2:0]                 iss_cls,
  input  logic [REG_W-1:0]           iss_dst,
  input  logic [REG_W-1:0]           iss_src_a,
  input  logic [REG_W-1:0]           iss_src_b,
  output logic                       iss_ready,
  output logic                       wb_valid,
  output logic [REG_W-1:0]           wb_dst,
  output logic [SEQ_W-1:0]           wb_seq,
  output logic [$clog2(NSLOT+1)-1:0] inflight
);
  import fu_sched_pkg::*;

  localparam int NREG  = 1 << REG_W;
  localparam int CNT_W = $clog2(NSLOT + 1);

  logic [NSLOT-1:0] slot_vld, slot_done, slot_div, slot_alloc, gnt;
  logic [REG_W-1:0] slot_dst [NSLOT];
  logic [SEQ_W-1:0] slot_seq [NSLOT];
  logic [NREG-1:0]  busy;
  logic [SEQ_W-1:0] seq_q, seq_d;
  logic [CNT_W-1:0] cnt;
  logic             accept, is_div, div_busy, full, hazard;

  assign is_div   = (iss_cls == CLS_DIV);
  assign div_busy = |(slot_vld & slot_div);
  assign full     = (cnt == CNT_W'(NSLOT));
  assign hazard   = busy[iss_src_a] | busy[iss_src_b] | busy[iss_dst];
  assign iss_ready = !full && !hazard && !(is_div && div_busy);
  assign accept    = iss_valid && iss_ready;

  // lowest free slot takes the new instruction
  always_comb begin
    slot_alloc = '0;
    cnt        = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (slot_vld[i]) cnt = cnt + 1'b1;
    end
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (!slot_vld[i]) begin
        slot_alloc    = '0;
        slot_alloc[i] = accept;
      end
    end
  end

  always_comb begin
    seq_d = seq_q;
    if (accept) seq_d = seq_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seq_q <= '0;
    else if (accept) seq_q <= seq_d;
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    fu_sched_slot #(.SEQ_W(SEQ_W), .REG_W(REG_W), .LAT_W(LAT_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .alloc     (slot_alloc[g]),
      .a_dst     (iss_dst),
      .a_seq     (seq_q),
      .a_wait    (cls_wait(iss_cls)),
      .a_div     (is_div),
      .release_i (gnt[g]),
      .vld       (slot_vld[g]),
      .done      (slot_done[g]),
      .dst       (slot_dst[g]),
      .seq       (slot_seq[g]),
      .is_div    (slot_div[g])
    );
  end

  fu_sched_wbarb #(.NSLOT(NSLOT), .SEQ_W(SEQ_W)) u_arb (
    .done (slot_done),
    .seq  (slot_seq),
    .gnt  (gnt)
  );

  always_comb begin
    wb_dst = '0;
    wb_seq = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (gnt[i]) begin
        wb_dst = slot_dst[i];
        wb_seq = slot_seq[i];
      end
    end
  end

  assign wb_valid = |gnt;

  fu_sched_sb #(.NREG(NREG), .REG_W(REG_W)) u_sb (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (accept),
    .set_idx (iss_dst),
    .clr_en  (wb_valid),
    .clr_idx (wb_dst),
    .busy    (busy)
  );

  assign inflight = cnt;
endmodule

// File: rtl/fu_sched_chk.sv
module fu_sched_chk #(
  parameter int NSLOT = 6,
  parameter int SEQ_W = 6
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       iss_ready,
  input logic                       wb_valid,
  input logic [$clog2(NSLOT+1)-1:0] inflight,
  input logic [NSLOT-1:0]           slot_vld,
  input logic [NSLOT-1:0]           slot_done,
  input logic [NSLOT-1:0]           slot_div,
  input logic [NSLOT-1:0]           gnt,
  input logic [SEQ_W-1:0]           slot_seq [NSLOT]
);
  logic             older_left;
  logic [SEQ_W-1:0] d;

  always_comb begin
    older_left = 1'b0;
    d          = '0;
    for (int i = 0; i < NSLOT; i++) begin
      for (int j = 0; j < NSLOT; j++) begin
        d = slot_seq[j] - slot_seq[i];
        if (gnt[i] && slot_done[j] && (i != j) && d[SEQ_W-1]) older_left = 1'b1;
      end
    end
  end

  AST_INFLIGHT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= ($clog2(NSLOT+1))'(NSLOT)); // R7
  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (inflight == ($clog2(NSLOT+1))'(NSLOT)) |-> !iss_ready); // R7
  AST_ONE_DIVIDE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(slot_vld & slot_div) <= 1); // R4
  AST_WB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt)); // R8
  AST_WB_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
    !older_left); // R8
  AST_WB_FROM_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> |slot_done); // R8

  for (genvar g = 0; g < NSLOT; g++) begin : g_hold
    AST_LOSER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_done[g] && !gnt[g]) |=> (slot_vld[g] && slot_done[g])); // R9
  end
endmodule

bind fu_sched fu_sched_chk #(.NSLOT(NSLOT), .SEQ_W(SEQ_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .iss_ready (iss_ready),
  .wb_valid  (wb_valid),
  .inflight  (inflight),
  .slot_vld  (slot_vld),
  .slot_done (slot_done),
  .slot_div  (slot_div),
  .gnt       (gnt),
  .slot_seq  (slot_seq)
);

// File: tb/fu_sched_tb.sv
`timescale 1ns/1ps
module fu_sched_tb;
  logic       clk, rst_n, iss_valid, iss_ready, wb_valid;
  logic [2:0] iss_cls, inflight;
  logic [4:0] iss_dst, iss_src_a, iss_src_b, wb_dst;
  logic [5:0] wb_seq;
  int n_chk, n_bad;
  logic last_ready, finished;

  fu_sched u_dut (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_cls(iss_cls),
    .iss_dst(iss_dst), .iss_src_a(iss_src_a), .iss_src_b(iss_src_b),
    .iss_ready(iss_ready), .wb_valid(wb_valid), .wb_dst(wb_dst),
    .wb_seq(wb_seq), .inflight(inflight)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // offers one instruction across one clock edge; returns just after that edge
  task automatic issue(input int cls, input int dst, input int sa, input int sb);
    iss_cls = 3'(cls); iss_dst = 5'(dst); iss_src_a = 5'(sa); iss_src_b = 5'(sb);
    iss_valid = 1'b1;
    #0.5 last_ready = iss_ready;
    @(posedge clk);
    #0.5 iss_valid = 1'b0;
  endtask

  task automatic probe(input int cls, input int dst, input int sa, input int sb,
                       input int exp, input string tag);
    iss_valid = 1'b0;
    iss_cls = 3'(cls); iss_dst = 5'(dst); iss_src_a = 5'(sa); iss_src_b = 5'(sb);
    #0.5 chk(iss_ready, exp, tag);
  endtask

  task automatic drain();
    for (int k = 0; k < 60 && (inflight != 0); k++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic lat_test(input int cls, input int lat, input int dst, input string tag);
    int n;
    @(negedge clk);
    issue(cls, dst, 0, 0);
    n = 1;
    @(negedge clk);
    while (!wb_valid && n < 40) begin @(negedge clk); n++; end
    chk(n, lat, tag);
    chk(wb_dst, dst, tag);
    drain();
  endtask

  task automatic t_reset();
    @(negedge clk);
    probe(0, 1, 0, 0, 1, "R1 ready");
    chk(wb_valid, 0, "R1 wb_valid");
    chk(inflight, 0, "R1 inflight");
  endtask

  task automatic t_pipe();
    int n;
    @(negedge clk);
    issue(3, 2, 0, 0);
    issue(3, 3, 0, 0);
    chk(last_ready, 1, "R3 second mul accepted");
    n = 1;
    @(negedge clk);
    while (!wb_valid && n < 40) begin @(negedge clk); n++; end
    chk(n, 5, "R3 first mul timing");
    chk(wb_dst, 2, "R3 first mul dst");
    @(negedge clk);
    chk(wb_valid, 1, "R3 second mul next cycle");
    chk(wb_dst, 3, "R3 second mul dst");
    drain();
  endtask

  task automatic t_div();
    @(negedge clk);
    issue(4, 4, 0, 0);
    probe(4, 5, 0, 0, 0, "R4 second divide held");
    probe(0, 5, 0, 0, 1, "R4 integer still issues");
    for (int k = 0; k < 40 && !wb_valid; k++) @(negedge clk);
    @(posedge clk);
    probe(4, 5, 0, 0, 1, "R4 divide free after writeback");
    drain();
  endtask

  task automatic t_hazard();
    @(negedge clk);
    issue(2, 6, 0, 0);
    probe(0, 8, 6, 0, 0, "R5 source a hazard");
    @(posedge clk);
    probe(0, 8, 0, 6, 0, "R5 source b hazard during writeback");
    @(posedge clk);
    probe(0, 8, 6, 6, 1, "R5 released after writeback");
    drain();
    @(negedge clk);
    issue(3, 7, 0, 0);
    probe(0, 7, 0, 0, 0, "R6 destination hazard");
    probe(0, 9, 0, 0, 1, "R6 other destination free");
    drain();
  endtask

  task automatic t_full();
    @(negedge clk);
    for (int k = 0; k < 6; k++) begin
      issue(3, 10 + k, 0, 0);
      chk(last_ready, 1, "R7 fill accepted");
    end
    chk(inflight, 6, "R7 six in flight");
    probe(0, 16, 0, 0, 0, "R7 seventh held");
    drain();
  endtask

  task automatic t_collide();
    @(negedge clk);
    issue(3, 20, 0, 0);
    @(posedge clk); @(posedge clk); @(posedge clk);
    #0.5 issue(2, 21, 0, 0);
    @(negedge clk);
    chk(wb_valid, 0, "R8 nothing finished yet");
    @(negedge clk);
    chk(wb_valid, 1, "R8 collision writeback");
    chk(wb_dst, 20, "R8 oldest wins");
    chk(inflight, 2, "R9 loser still in flight");
    @(negedge clk);
    chk(wb_valid, 1, "R9 loser written later");
    chk(wb_dst, 21, "R9 loser dst");
    @(negedge clk);
    chk(wb_valid, 0, "R9 no duplicate");
    drain();
  endtask

  initial begin
    n_chk = 0; n_bad = 0; finished = 1'b0;
    iss_valid = 0; iss_cls = 0; iss_dst = 0; iss_src_a = 0; iss_src_b = 0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    lat_test(0, 1, 1, "R2 integer latency");
    lat_test(1, 1, 2, "R2 memory latency");
    lat_test(2, 2, 3, "R2 fp add latency");
    lat_test(3, 6, 4, "R2 multiply latency");
    lat_test(4, 15, 5, "R2 divide latency");
    t_pipe();
    t_div();
    t_hazard();
    t_full();
    t_collide();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule